// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive path directly after the MAC framing logic. It inspects the destination address in the first six bytes of every frame and decides whether the frame goes on to the host side or is discarded. A frame is accepted in four cases. Its destination is the all-ones broadcast address. Its destination exactly equals the programmed station address. It is a group address whose CRC-derived hash selects a set bit in a 64-entry table. Or the filter is in promiscuous mode. Any other frame never reaches the output and raises no notification, so a rejected frame costs the host neither an interrupt nor bus bandwidth.

Input and output are byte streams with start-of-frame and end-of-frame markers. The filter delays the stream by a short line whose length equals the address length. This lets the verdict, taken when the last address byte arrives, gate the whole frame including its header. When an accepted frame leaves the block, a one-cycle notification pulse comes with its final byte and carries the reason for acceptance. A small write-only register port sets the station address, the hash table and the promiscuous flag, and these can change while traffic runs. The hash is imperfect by design: unrelated group addresses that land on a set bit also pass.

Top module: `eth_da_filter`

## Requirements
- R1: After reset, out_valid and rx_notify are low, the station address is all zeros (a frame sent to 00:00:00:00:00:00 is accepted as unicast), the hash table is all clear and promiscuous mode is off.
- R2: A frame whose six destination bytes equal the station address is accepted with rx_kind 0. The first byte received is the most significant byte. The station address is written as cfg_addr 0 (wdata = address bits 31:0) and cfg_addr 1 (wdata[15:0] = address bits 47:32).
- R3: A frame that matches no accept rule produces no out_valid byte and no rx_notify pulse.
- R4: A destination of all 48 ones is always accepted with rx_kind 1, whatever the table and the station address hold.
- R5: A group address (bit 0 of the first destination byte set, not broadcast) is accepted with rx_kind 2 exactly when hash table bit idx is set. A 32-bit register starts all ones and takes each destination byte first to last, bit 0 first. Per bit, it shifts right and XORs 0xEDB88320 when its bit 0 differs from the data bit. idx is that register's bits 31:26, with no final inversion. Different addresses that share an index are both accepted.
- R6: With promiscuous mode on (cfg_addr 4, wdata bit 0), every frame of at least six bytes is accepted. The kind is 1 or 0 when broadcast or station matching applies, 2 on a hash hit, and 3 otherwise.
- R7: Accepted frames leave in arrival order with every byte, start and end marker unaltered. rx_notify pulses in the same cycle as the frame's final output byte and carries the kind.
- R8: Frames that end before their sixth byte are dropped, including the case where a valid frame follows with no idle cycle.
- R9: Table words are written at run time: cfg_addr 2 holds table bits 31:0 and cfg_addr 3 holds bits 63:32. A change applies to frames whose sixth byte arrives after the write.
- R10: Back-to-back frames with no idle cycle, frames of exactly six bytes and input gaps inside a frame are all handled. The tail of the last frame drains without further input.
- R11: The verdict is fixed at the sixth byte. A configuration write later in the same frame does not change that frame's fate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| in_data | input | 8 | Input byte |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| out_valid | output | 1 | Output byte valid (accepted frames only) |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_data | output | 8 | Output byte |
| rx_notify | output | 1 | One-cycle pulse per accepted frame, with its last byte |
| rx_kind | output | 2 | Acceptance reason: 0 station, 1 broadcast, 2 hash, 3 promiscuous |

## Verification
Every cycle, the assertions check three things. A broadcast or promiscuous verdict always accepts. A header byte whose verdict is still open never leaves the delay line. A byte marked for discard never shows up as output or notification. They also check that a promiscuous-flag write takes effect and that the header position counter stays in range. Only the bench scenarios can show the rest. That includes whether the hash index matches the independently computed CRC, whether false positives pass and whether run-time table edits change later frames. It also includes the verdict holding against a write made mid-frame, and whether runt and back-to-back sequences deliver exactly the right bytes in the right order.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;

  typedef enum logic [1:0] {
    KIND_UCAST   = 2'd0,
    KIND_BCAST   = 2'd1,
    KIND_MCAST   = 2'd2,
    KIND_PROMISC = 2'd3
  } kind_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  // one slot of the header delay line
  typedef struct packed {
    logic       valid;
    logic       sof;
    logic       eof;
    logic       pending;  // verdict for this byte not yet known
    logic       keep;
    kind_e      kind;
    logic [7:0] data;
  } slot_t;

  // reflected CRC-32 step over one byte, bit 0 first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/daf_hdr_track.sv
module daf_hdr_track
  import eth_daf_pkg::*;
#(
  parameter int DA_BYTES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic                  in_eof,
  input  logic [7:0]            in_data,
  output logic [DA_BYTES*8-1:0] da_full,
  output logic [31:0]           crc_now,
  output logic                  resolve,
  output logic                  runt_end
);

  localparam int CW = $clog2(DA_BYTES + 1);
  localparam int HW = (DA_BYTES - 1) * 8;
  localparam logic [CW-1:0] LAST = CW'(DA_BYTES - 1);
  localparam logic [CW-1:0] FULL = CW'(DA_BYTES);

  logic [CW-1:0] cnt_q, cnt_d, pos;
  logic [HW-1:0] hdr_q, hdr_d;
  logic [31:0]   crc_q, crc_d, crc_seed;
  logic          in_hdr;

  // byte position of the current beat inside its frame
  always_comb begin
    pos      = in_sof ? '0 : cnt_q;
    in_hdr   = (pos < FULL);
    crc_seed = (pos == '0) ? '1 : crc_q;
    crc_now  = crc32_byte(crc_seed, in_data);
    da_full  = {hdr_q, in_data};
    resolve  = in_valid && (pos == LAST);
    runt_end = in_valid && in_eof && (pos < LAST);
  end

  always_comb begin
    cnt_d = cnt_q;
    hdr_d = hdr_q;
    crc_d = crc_q;
    if (in_valid) begin
      if (in_eof)      cnt_d = '0;
      else if (in_hdr) cnt_d = pos + CW'(1);
      if (pos < LAST)  hdr_d = {hdr_q[HW-9:0], in_data};
      if (in_hdr)      crc_d = crc_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hdr_q <= '0;
      crc_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      hdr_q <= hdr_d;
      crc_q <= crc_d;
    end
  end

  // R10: header position never runs past the address length
  a_r10_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);

endmodule

// File: rtl/daf_verdict.sv
module daf_verdict
  import eth_daf_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6,
  parameter int CFG_AW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [CFG_AW-1:0]     cfg_addr,
  input  logic [31:0]           cfg_wdata,
  input  logic [DA_BYTES*8-1:0] da,
  input  logic [31:0]           crc,
  input  logic                  resolve,
  output logic                  accept,
  output kind_e                 kind
);

  localparam int DAW      = DA_BYTES * 8;
  localparam int TBL      = 1 << HASH_BITS;
  localparam int HWORDS   = TBL / 32;
  localparam int SWORDS   = (DAW + 31) / 32;
  localparam int A_HASH   = SWORDS;
  localparam int A_PROMIS = SWORDS + HWORDS;

  logic [SWORDS*32-1:0] sta_all;
  logic [TBL-1:0]       tbl_all;
  logic                 promisc_q, promisc_d;

  // station address words
  for (genvar g = 0; g < SWORDS; g++) begin : gen_sta
    logic [31:0] word_q, word_d;
    always_comb begin
      word_d = word_q;
      if (cfg_we && cfg_addr == CFG_AW'(g)) word_d = cfg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign sta_all[g*32 +: 32] = word_q;
  end

  // hash table words
  for (genvar g = 0; g < HWORDS; g++) begin : gen_tbl
    logic [31:0] word_q, word_d;
    always_comb begin
      word_d = word_q;
      if (cfg_we && cfg_addr == CFG_AW'(A_HASH + g)) word_d = cfg_wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end
    assign tbl_all[g*32 +: 32] = word_q;
  end

  always_comb begin
    promisc_d = promisc_q;
    if (cfg_we && cfg_addr == CFG_AW'(A_PROMIS)) promisc_d = cfg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) promisc_q <= 1'b0;
    else        promisc_q <= promisc_d;
  end

  logic                 is_bcast, is_group, ucast_hit, mcast_hit;
  logic [HASH_BITS-1:0] hidx;

  always_comb begin
    is_bcast  = &da;
    is_group  = da[DAW-8];
    ucast_hit = (da == sta_all[DAW-1:0]);
    hidx      = crc[31 -: HASH_BITS];
    mcast_hit = is_group && !is_bcast && tbl_all[hidx];
    accept    = 1'b1;
    kind      = KIND_UCAST;
    if (is_bcast)       kind = KIND_BCAST;
    else if (ucast_hit) kind = KIND_UCAST;
    else if (mcast_hit) kind = KIND_MCAST;
    else if (promisc_q) kind = KIND_PROMISC;
    else                accept = 1'b0;
  end

  // R4: broadcast is always taken, with its own kind
  a_r4_bcast_always: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && (&da)) |-> (accept && kind == KIND_BCAST));

  // R6: promiscuous mode never rejects
  a_r6_promisc_all: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && promisc_q) |-> accept);

  // R6: promiscuous flag follows its register write
  a_r6_promisc_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == CFG_AW'(A_PROMIS)) |=> (promisc_q == $past(cfg_wdata[0])));

endmodule

// File: rtl/daf_delay_line.sv
module daf_delay_line
  import eth_daf_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic       in_eof,
  input  logic [7:0] in_data,
  input  logic       resolve,
  input  logic       runt_end,
  input  logic       dec_accept,
  input  kind_e      dec_kind,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof,
  output logic [7:0] out_data,
  output logic       rx_notify,
  output kind_e      rx_kind
);

  localparam int FW = $clog2(DEPTH + 1);

  slot_t   slot_q   [DEPTH];
  slot_t   slot_fix [DEPTH];
  slot_t   inc;
  logic    shift;
  logic [FW-1:0] flush_q, flush_d;
  logic    done_q, done_d, keep_q, keep_d;
  kind_e   kind_q, kind_d;
  logic    ov_d, os_d, oe_d, nt_d;
  logic [7:0] od_d;
  kind_e   ok_d;

  assign shift = in_valid || (flush_q != '0);

  // incoming byte tagged with what is known about its frame
  always_comb begin
    inc         = '0;
    inc.valid   = in_valid;
    inc.sof     = in_sof;
    inc.eof     = in_eof;
    inc.data    = in_data;
    inc.kind    = KIND_UCAST;
    if (resolve) begin
      inc.keep = dec_accept;
      inc.kind = dec_kind;
    end else if (runt_end) begin
      inc.keep = 1'b0;
    end else if (in_sof || !done_q) begin
      inc.pending = in_valid;
    end else begin
      inc.keep = keep_q;
      inc.kind = kind_q;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gen_slot
    slot_t nxt;
    always_comb begin
      slot_fix[g] = slot_q[g];
      if (slot_q[g].pending && (resolve || runt_end)) begin
        slot_fix[g].pending = 1'b0;
        slot_fix[g].keep    = resolve && dec_accept;
        slot_fix[g].kind    = resolve ? dec_kind : KIND_UCAST;
      end
    end
    if (g == 0) begin : gen_head
      always_comb nxt = shift ? inc : slot_fix[g];
    end else begin : gen_body
      always_comb nxt = shift ? slot_fix[g-1] : slot_fix[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else        slot_q[g] <= nxt;
    end
  end

  // frame verdict, flush counter and output stage
  always_comb begin
    done_d  = done_q;
    keep_d  = keep_q;
    kind_d  = kind_q;
    flush_d = flush_q;
    if (resolve) begin
      done_d = 1'b1;
      keep_d = dec_accept;
      kind_d = dec_kind;
    end else if (runt_end) begin
      done_d = 1'b1;
      keep_d = 1'b0;
    end else if (in_valid && in_sof) begin
      done_d = 1'b0;
    end
    if (in_valid && in_eof)      flush_d = FW'(DEPTH);
    else if (in_valid && in_sof) flush_d = '0;
    else if (shift && flush_q != '0) flush_d = flush_q - FW'(1);

    ov_d = 1'b0;
    os_d = 1'b0;
    oe_d = 1'b0;
    od_d = '0;
    nt_d = 1'b0;
    ok_d = KIND_UCAST;
    if (shift) begin
      ov_d = slot_q[DEPTH-1].valid && slot_q[DEPTH-1].keep;
      os_d = slot_q[DEPTH-1].sof;
      oe_d = slot_q[DEPTH-1].eof;
      od_d = slot_q[DEPTH-1].data;
      nt_d = ov_d && slot_q[DEPTH-1].eof;
      ok_d = slot_q[DEPTH-1].kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b1;
      keep_q    <= 1'b0;
      kind_q    <= KIND_UCAST;
      flush_q   <= '0;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      out_data  <= '0;
      rx_notify <= 1'b0;
      rx_kind   <= KIND_UCAST;
    end else begin
      done_q    <= done_d;
      keep_q    <= keep_d;
      kind_q    <= kind_d;
      flush_q   <= flush_d;
      out_valid <= ov_d;
      out_sof   <= os_d;
      out_eof   <= oe_d;
      out_data  <= od_d;
      rx_notify <= nt_d;
      rx_kind   <= ok_d;
    end
  end

  // R7: no byte leaves before its frame verdict is known
  a_r7_no_pending_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && slot_q[DEPTH-1].valid) |-> !slot_q[DEPTH-1].pending);

  // R3: a discarded byte produces neither output nor notification
  a_r3_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && slot_q[DEPTH-1].valid && !slot_q[DEPTH-1].keep) |=> (!out_valid && !rx_notify));

  // R10: drain counter stays within the line length
  a_r10_flush_bound: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q <= FW'(DEPTH));

endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_daf_pkg::*;
#(
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6,
  parameter int CFG_AW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_data,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic [7:0]        out_data,
  output logic              rx_notify,
  output logic [1:0]        rx_kind
);

  localparam int DAW = DA_BYTES * 8;

  logic rst_meta, rst_sync_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [DAW-1:0] da_full;
  logic [31:0]    crc_now;
  logic           resolve, runt_end, dec_accept;
  kind_e          dec_kind, kind_out;

  daf_hdr_track #(.DA_BYTES(DA_BYTES)) u_hdr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_data  (in_data),
    .da_full  (da_full),
    .crc_now  (crc_now),
    .resolve  (resolve),
    .runt_end (runt_end)
  );

  daf_verdict #(.DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS), .CFG_AW(CFG_AW)) u_verdict (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .da        (da_full),
    .crc       (crc_now),
    .resolve   (resolve),
    .accept    (dec_accept),
    .kind      (dec_kind)
  );

  daf_delay_line #(.DEPTH(DA_BYTES)) u_line (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_data    (in_data),
    .resolve    (resolve),
    .runt_end   (runt_end),
    .dec_accept (dec_accept),
    .dec_kind   (dec_kind),
    .out_valid  (out_valid),
    .out_sof    (out_sof),
    .out_eof    (out_eof),
    .out_data   (out_data),
    .rx_notify  (rx_notify),
    .rx_kind    (kind_out)
  );

  assign rx_kind = kind_out;

endmodule

// File: tb/eth_da_filter_tb_top.sv
module eth_da_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_data;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        out_valid, out_sof, out_eof, rx_notify;
  logic [7:0]  out_data;
  logic [1:0]  rx_kind;

  always #5 clk = ~clk;

  eth_da_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof), .out_data(out_data),
    .rx_notify(rx_notify), .rx_kind(rx_kind)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;

  logic [9:0] exp_b  [$];
  string      exp_bt [$];
  logic [1:0] exp_k  [$];
  string      exp_kt [$];
  logic [9:0] e_b;
  logic [1:0] e_k;
  string      e_t;

  localparam logic [47:0] STA   = 48'h0211_2233_4455;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
  logic [63:0] tbl_m;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [5:0] hash_idx(input logic [47:0] da);
    logic [31:0] c;
    logic [7:0]  d;
    c = '1;
    for (int b = 0; b < 6; b++) begin
      d = da[47-8*b -: 8];
      for (int i = 0; i < 8; i++)
        c = (c[0] ^ d[i]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c[31:26];
  endfunction

  function automatic logic [7:0] byte_at(input logic [47:0] da, input int len, input int i);
    if (i < 6) return da[47-8*i -: 8];
    return 8'(i * 7 + len);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_b.size() == 0) begin
          chk(1'b0, "R3", "unexpected output byte", {out_sof, out_eof, out_data}, 0);
        end else begin
          e_b = exp_b.pop_front();
          e_t = exp_bt.pop_front();
          chk({out_sof, out_eof, out_data} == e_b, e_t, "output byte {sof,eof,data}",
              {out_sof, out_eof, out_data}, e_b);
        end
      end
      if (rx_notify) begin
        chk(out_valid && out_eof, "R7", "notify aligned with last byte",
            {out_valid, out_eof}, 2'b11);
        if (exp_k.size() == 0) begin
          chk(1'b0, "R3", "unexpected notify", rx_kind, 0);
        end else begin
          e_k = exp_k.pop_front();
          e_t = exp_kt.pop_front();
          chk(rx_kind == e_k, e_t, "notify kind", rx_kind, e_k);
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_station(input logic [47:0] s);
    cfg_write(3'd0, s[31:0]);
    cfg_write(3'd1, {16'h0, s[47:32]});
  endtask

  task automatic load_table();
    cfg_write(3'd2, tbl_m[31:0]);
    cfg_write(3'd3, tbl_m[63:32]);
  endtask

  task automatic send_frame(input logic [47:0] da, input int len, input int gap,
                            input bit acc, input logic [1:0] kind, input string tag,
                            input int wr_at = -1, input logic [2:0] wr_a = 3'd0,
                            input logic [31:0] wr_d = 32'h0);
    if (acc) begin
      for (int i = 0; i < len; i++) begin
        exp_b.push_back({(i == 0), (i == len - 1), byte_at(da, len, i)});
        exp_bt.push_back(tag);
      end
      exp_k.push_back(kind);
      exp_kt.push_back(tag);
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_data   = byte_at(da, len, i);
      cfg_we    = (i == wr_at);
      cfg_addr  = wr_a;
      cfg_wdata = wr_d;
      if (gap > 0 && i < len - 1) begin
        repeat (gap) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; cfg_we = 1'b0;
        end
      end
    end
  endtask

  task automatic drained(input string tag);
    idle(16);
    chk(exp_b.size() == 0 && exp_k.size() == 0, tag, "all expected output delivered",
        exp_b.size() + exp_k.size(), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [47:0] m1, m2, m3;
    logic [5:0]  i1;
    bit          found;
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; tbl_m = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    // R1: reset state of outputs and configuration
    chk(!out_valid && !rx_notify, "R1", "outputs idle after reset", {out_valid, rx_notify}, 0);
    send_frame(48'h0, 10, 0, 1'b1, 2'd0, "R1");
    m1 = 48'h0100_5E00_002A;
    send_frame(m1, 12, 0, 1'b0, 2'd0, "R1");
    drained("R1");

    set_station(STA);
    // R2: exact station match
    send_frame(STA, 20, 0, 1'b1, 2'd0, "R2");
    drained("R2");

    // R3: near miss unicast and unrelated unicast dropped
    send_frame(STA ^ 48'h1 << 1, 15, 0, 1'b0, 2'd0, "R3");
    send_frame(48'h0400_1122_3344, 11, 0, 1'b0, 2'd0, "R3");
    drained("R3");

    // R4: broadcast always accepted
    send_frame(BCAST, 16, 0, 1'b1, 2'd1, "R4");
    drained("R4");

    // R5 / R9: hashed group filtering, run-time table edits
    i1 = hash_idx(m1);
    send_frame(m1, 12, 0, 1'b0, 2'd0, "R5");
    drained("R5");
    tbl_m[i1] = 1'b1;
    load_table();
    send_frame(m1, 12, 0, 1'b1, 2'd2, "R9");
    found = 1'b0;
    m2 = m1;
    for (int k = 1; k < 4096 && !found; k++) begin
      m2 = {24'h01005E, 8'h01, 16'(k)};
      if (m2 != m1 && hash_idx(m2) == i1) found = 1'b1;
    end
    chk(found, "R5", "alias search", found, 1);
    send_frame(m2, 9, 0, 1'b1, 2'd2, "R5");
    m3 = m1;
    for (int k = 1; k < 4096; k++) begin
      m3 = {24'h01005E, 8'h02, 16'(k)};
      if (hash_idx(m3) != i1) break;
    end
    send_frame(m3, 9, 0, 1'b0, 2'd0, "R5");
    drained("R5");
    tbl_m = '0;
    load_table();
    send_frame(m1, 12, 0, 1'b0, 2'd0, "R9");
    drained("R9");

    // R6: promiscuous mode
    cfg_write(3'd4, 32'h1);
    send_frame(STA ^ 48'h2, 10, 0, 1'b1, 2'd3, "R6");
    send_frame(BCAST, 8, 0, 1'b1, 2'd1, "R6");
    send_frame(STA, 8, 0, 1'b1, 2'd0, "R6");
    drained("R6");
    cfg_write(3'd4, 32'h0);
    send_frame(STA ^ 48'h2, 10, 0, 1'b0, 2'd0, "R6");
    drained("R6");

    // R8: runts dropped, also when followed at once by a good frame
    send_frame(BCAST, 4, 0, 1'b0, 2'd0, "R8");
    idle(2);
    send_frame(STA, 5, 0, 1'b0, 2'd0, "R8");
    send_frame(BCAST, 3, 0, 1'b0, 2'd0, "R8");
    send_frame(STA, 10, 0, 1'b1, 2'd0, "R8");
    drained("R8");

    // R10: back-to-back mix, exact six-byte frame, drain without input
    send_frame(STA, 12, 0, 1'b1, 2'd0, "R10");
    send_frame(STA ^ 48'h4, 9, 0, 1'b0, 2'd0, "R10");
    send_frame(BCAST, 7, 0, 1'b1, 2'd1, "R10");
    send_frame(STA, 6, 0, 1'b1, 2'd0, "R10");
    drained("R10");

    // R7: gaps inside a frame keep bytes and markers intact
    send_frame(STA, 9, 2, 1'b1, 2'd0, "R7");
    send_frame(BCAST, 7, 1, 1'b1, 2'd1, "R7");
    drained("R7");

    // R11: a write after the sixth byte does not alter the verdict
    send_frame(STA, 14, 0, 1'b1, 2'd0, "R11", 8, 3'd0, 32'h0);
    drained("R11");
    send_frame(STA, 10, 0, 1'b0, 2'd0, "R11");
    drained("R11");
    set_station(STA);
    send_frame(STA, 8, 0, 1'b1, 2'd0, "R2");
    drained("R2");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog run did not complete");
      summary();
      $finish;
    end
  end

endmodule